// File: doc/BRIEF.md
# UART Status Flag and Interrupt Unit

This block keeps the status bits of a serial port and turns them into one interrupt line. Pulses from the receiver and the transmitter are caught in sticky flags that software clears by writing ones. The block also keeps three level flags. The first is a live view of the RTS input. The second is a transmit-ready flag that follows the transmit FIFO fill level against a programmable threshold. The third is a receiver-idle flag. Every flag is ANDed with its own enable bit, and the results are ORed onto a single interrupt output.

The RTS input is asynchronous, so the block synchronises it before it looks for edges. In stop mode only an assertion of RTS, a high-to-low change, is recorded, and a recorded change drives a wake output. Detecting characters, start bits and errors is left to the receiver. This block only sees the resulting pulses.

Top module: `uart_stat_irq`

## Requirements
- R1: Status bits 0 (parity error), 1 (frame error), 2 (RTS change), 3 (escape), 4 (wake), 5 (transmit complete), 6 (break) and 7 (overrun) are sticky. Each one reads 1 from the cycle after its event pulse. Each resets to 0. A cycle with `wr_en` high and a 1 in that bit of `wr_clr` clears it. A 0 in that bit leaves it unchanged.
- R2: If an event pulse and a clearing write reach the same sticky bit in the same cycle, the bit is 1 afterwards.
- R3: While `parity_en` is low, status bit 0 reads 0 and parity-error pulses are not recorded. Once `parity_en` is high again, a parity error that was recorded earlier reads back as 1.
- R4: Status bit 8 reads 1 when `rts_n` is low and 0 when it is high. It follows the pin two clock edges after a change. It resets to 0, and no write changes it.
- R5: Outside stop mode, a change of `rts_n` in either direction sets bit 2 three clock edges after the change.
- R6: While `stop_mode` is high, only a high-to-low change of `rts_n` sets bit 2. The output `wake` is high exactly when `stop_mode` and bit 2 are both high.
- R7: Status bit 9 (transmit ready) resets to 1. One cycle after `tx_level` and `tx_thr` are presented, it reads 1 if `tx_level` is at most the threshold and 0 if it is above it.
- R8: A `tx_thr` code below 2 acts as a threshold of 2. A code above 32 acts as a threshold of 32.
- R9: Status bit 10 (receiver idle) resets to 1. It reads 0 in the cycle after `rx_char_done`. It reads 1 in the cycle after `rx_idle_now` and `rx_pin` are both high while `rx_char_done` is low. Otherwise it holds its value.
- R10: `irq` is high exactly when some status bit other than bit 8 is 1 and its bit in `irq_en` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| parity_en | input | 1 | Parity checking enabled |
| ev_parity | input | 1 | Parity error pulse |
| ev_frame | input | 1 | Frame error pulse |
| ev_escape | input | 1 | Escape sequence pulse |
| ev_wake | input | 1 | Receiver start-bit pulse |
| ev_txdone | input | 1 | Transmission complete pulse |
| ev_break | input | 1 | Break detected pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| rts_n | input | 1 | RTS pin, low = active, asynchronous |
| stop_mode | input | 1 | Chip in stop mode |
| rx_idle_now | input | 1 | Receive state machine idle now and in the next state |
| rx_pin | input | 1 | Receive line level |
| rx_char_done | input | 1 | Character received pulse |
| tx_level | input | 6 | Transmit FIFO fill level |
| tx_thr | input | 6 | Transmit threshold code |
| wr_en | input | 1 | Clearing write strobe |
| wr_clr | input | 8 | Write-one-to-clear mask for bits 0 to 7 |
| irq_en | input | 11 | Interrupt enable per status bit |
| status | output | 11 | Status word |
| irq | output | 1 | Combined interrupt |
| wake | output | 1 | Wake request in stop mode |

## Verification
Two cases are hard to reach from the ports. The first is the stop-mode filter on RTS changes. It acts only on an edge that has already passed through the synchroniser, so the bench enters stop mode, drives both pin directions, and samples bit 2 and `wake` on the third edge after each change. The second is the race between an event and a clear. The bench raises an event pulse and a clearing write in the same cycle. It also covers the parity gate by recording an error, turning parity off and then back on, and checking that the stored bit reappears.

// File: rtl/uart_stat_pkg.sv
// Package: shared layout of the status word for the UART status unit.
// Assumes the sticky flags sit in the low bits so a clear mask maps one-to-one.
package uart_stat_pkg;
    localparam int NUM_STICKY = 8;
    localparam int FLAG_W     = 11;
    localparam int IDX_PAR    = 0;
    localparam int IDX_FRM    = 1;
    localparam int IDX_RTSD   = 2;
    localparam int IDX_ESC    = 3;
    localparam int IDX_WAKE   = 4;
    localparam int IDX_TXC    = 5;
    localparam int IDX_BRK    = 6;
    localparam int IDX_ORE    = 7;
    localparam int IDX_RTSS   = 8;
    localparam int IDX_TXRDY  = 9;
    localparam int IDX_RXIDLE = 10;
    // Bits that may raise the interrupt (live RTS level excluded).
    localparam logic [FLAG_W-1:0] IRQ_MASK = ~(FLAG_W'(1) << IDX_RTSS);
endpackage

// File: rtl/uart_rts_mon.sv
// Module: synchronises the RTS pin and produces a change pulse.
// Assumes the pin is asynchronous and idles high (inactive); STAGES >= 2.
module uart_rts_mon #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_n,
    input  logic stop_mode,
    output logic rts_active,
    output logic delta_ev
);
    logic [STAGES:0] shreg;
    logic            sync_q;
    logic            prev_q;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], rts_n};
    end

    assign sync_q     = shreg[STAGES-1];
    assign prev_q     = shreg[STAGES];
    assign rts_active = ~sync_q;

    // Any edge in normal mode, only the falling (asserting) edge in stop mode.
    always_comb begin
        if (stop_mode) delta_ev = prev_q & ~sync_q;
        else           delta_ev = prev_q ^ sync_q;
    end
endmodule

// File: rtl/uart_sticky_bank.sv
// Module: bank of write-one-to-clear flags where an event beats a clear.
// Assumes events are single-cycle pulses in the clock domain.
module uart_sticky_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         wr_en,
    input  logic [N-1:0] wr_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: set by its event, cleared by a write of 1, else held.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[i] <= 1'b0;
            else if (ev[i])                  flags[i] <= 1'b1;
            else if (wr_en && wr_clr[i])     flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_level_flags.sv
// Module: transmit-ready and receiver-idle level flags.
// Assumes threshold codes outside TX_MIN..TX_MAX are clamped into range.
module uart_level_flags #(
    parameter int LVL_W  = 6,
    parameter int TX_MIN = 2,
    parameter int TX_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic             rx_idle_now,
    input  logic             rx_pin,
    input  logic             rx_char_done,
    output logic             tx_ready,
    output logic             rx_idle
);
    localparam logic [LVL_W-1:0] MIN_V = LVL_W'(TX_MIN);
    localparam logic [LVL_W-1:0] MAX_V = LVL_W'(TX_MAX);
    logic [LVL_W-1:0] thr_eff;

    // Clamp reserved threshold codes onto the nearest legal value.
    always_comb begin
        if (tx_thr < MIN_V)      thr_eff = MIN_V;
        else if (tx_thr > MAX_V) thr_eff = MAX_V;
        else                     thr_eff = tx_thr;
    end

    // Transmit ready tracks level against threshold, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_ready <= 1'b1;
        else        tx_ready <= (tx_level <= thr_eff);
    end

    // Receiver idle: a received character clears it, an idle high line sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rx_idle <= 1'b1;
        else if (rx_char_done)          rx_idle <= 1'b0;
        else if (rx_idle_now && rx_pin) rx_idle <= 1'b1;
    end
endmodule

// File: rtl/uart_stat_irq.sv
// Module: top of the UART status unit; assembles the status word and interrupt.
// Assumes all event inputs are synchronous pulses; only rts_n is asynchronous.
module uart_stat_irq
    import uart_stat_pkg::*;
#(
    parameter int LVL_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              parity_en,
    input  logic              ev_parity,
    input  logic              ev_frame,
    input  logic              ev_escape,
    input  logic              ev_wake,
    input  logic              ev_txdone,
    input  logic              ev_break,
    input  logic              ev_overrun,
    input  logic              rts_n,
    input  logic              stop_mode,
    input  logic              rx_idle_now,
    input  logic              rx_pin,
    input  logic              rx_char_done,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  tx_thr,
    input  logic              wr_en,
    input  logic [NUM_STICKY-1:0] wr_clr,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [FLAG_W-1:0] status,
    output logic              irq,
    output logic              wake
);
    logic [NUM_STICKY-1:0] ev_vec;
    logic [NUM_STICKY-1:0] sticky_q;
    logic rts_active, rts_delta_ev, tx_ready, rx_idle;

    uart_rts_mon #(.STAGES(SYNC_STAGES)) rts_i (
        .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .stop_mode(stop_mode),
        .rts_active(rts_active), .delta_ev(rts_delta_ev)
    );

    // Gather event pulses into status-bit order; parity only counts when enabled.
    always_comb begin
        ev_vec           = '0;
        ev_vec[IDX_PAR]  = ev_parity & parity_en;
        ev_vec[IDX_FRM]  = ev_frame;
        ev_vec[IDX_RTSD] = rts_delta_ev;
        ev_vec[IDX_ESC]  = ev_escape;
        ev_vec[IDX_WAKE] = ev_wake;
        ev_vec[IDX_TXC]  = ev_txdone;
        ev_vec[IDX_BRK]  = ev_break;
        ev_vec[IDX_ORE]  = ev_overrun;
    end

    uart_sticky_bank #(.N(NUM_STICKY)) stick_i (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .wr_en(wr_en),
        .wr_clr(wr_clr), .flags(sticky_q)
    );

    uart_level_flags #(.LVL_W(LVL_W)) lvl_i (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_thr(tx_thr),
        .rx_idle_now(rx_idle_now), .rx_pin(rx_pin), .rx_char_done(rx_char_done),
        .tx_ready(tx_ready), .rx_idle(rx_idle)
    );

    // Status word: sticky bits with parity masked, then the level flags.
    always_comb begin
        status                     = '0;
        status[NUM_STICKY-1:0]     = sticky_q;
        status[IDX_PAR]            = sticky_q[IDX_PAR] & parity_en;
        status[IDX_RTSS]           = rts_active;
        status[IDX_TXRDY]          = tx_ready;
        status[IDX_RXIDLE]         = rx_idle;
    end

    // Combined interrupt and stop-mode wake request.
    assign irq  = |(status & irq_en & IRQ_MASK);
    assign wake = stop_mode & sticky_q[IDX_RTSD];
endmodule

// File: rtl/uart_stat_irq_chk.sv
// Module: property checker for uart_stat_irq, attached by bind.
// Assumes default parameters of the top module.
module uart_stat_irq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        parity_en,
    input logic        ev_frame,
    input logic        stop_mode,
    input logic        rx_char_done,
    input logic [5:0]  tx_level,
    input logic        wr_en,
    input logic [7:0]  wr_clr,
    input logic [10:0] irq_en,
    input logic [10:0] status,
    input logic        irq,
    input logic        wake
);
    AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(wr_en && wr_clr[1])) |=> status[1]); // R1
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |=> status[1]); // R2
    AST_PARITY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !parity_en |-> !status[0]); // R3
    AST_WAKE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (stop_mode && status[2])); // R6
    AST_TXRDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= 6'd2) |=> status[9]); // R7
    AST_RXIDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_done |=> !status[10]); // R9
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && irq_en[1]) |-> irq); // R10
endmodule

bind uart_stat_irq uart_stat_irq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .parity_en(parity_en), .ev_frame(ev_frame),
    .stop_mode(stop_mode), .rx_char_done(rx_char_done), .tx_level(tx_level),
    .wr_en(wr_en), .wr_clr(wr_clr), .irq_en(irq_en), .status(status),
    .irq(irq), .wake(wake)
);

// File: tb/uart_stat_irq_tb_top.sv
// Bench: table walk for transmit-ready thresholds, then directed flag tests.
module uart_stat_irq_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic parity_en, ev_parity, ev_frame, ev_escape, ev_wake, ev_txdone;
    logic ev_break, ev_overrun, rts_n, stop_mode, rx_idle_now, rx_pin, rx_char_done;
    logic [5:0]  tx_level, tx_thr;
    logic        wr_en;
    logic [7:0]  wr_clr;
    logic [10:0] irq_en;
    logic [10:0] status;
    logic        irq, wake;
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    uart_stat_irq dut_i (.*);

    // {tx_level, tx_thr, expected ready}
    localparam logic [12:0] TXTAB [10] = '{
        {6'd0,  6'd0,  1'b1}, {6'd2,  6'd0,  1'b1}, {6'd3,  6'd1,  1'b0},
        {6'd2,  6'd2,  1'b1}, {6'd3,  6'd2,  1'b0}, {6'd31, 6'd31, 1'b1},
        {6'd32, 6'd31, 1'b0}, {6'd32, 6'd63, 1'b1}, {6'd33, 6'd63, 1'b0},
        {6'd32, 6'd40, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clr(logic [7:0] m);
        wr_en = 1'b1; wr_clr = m;
        tick();
        wr_en = 1'b0; wr_clr = '0;
    endtask

    initial begin
        #4000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; parity_en = 1'b1; ev_parity = 0; ev_frame = 0; ev_escape = 0;
        ev_wake = 0; ev_txdone = 0; ev_break = 0; ev_overrun = 0; rts_n = 1'b1;
        stop_mode = 0; rx_idle_now = 0; rx_pin = 1; rx_char_done = 0;
        tx_level = 0; tx_thr = 6'd2; wr_en = 0; wr_clr = 0; irq_en = 0;
        tick(); tick();
        check("R7 R9 reset status", status, 11'h600);
        check("R10 reset irq", irq, 0);
        rst_n = 1'b1;

        // R7 R8 threshold table
        for (int i = 0; i < 10; i++) begin
            tx_level = TXTAB[i][12:7]; tx_thr = TXTAB[i][6:1];
            tick();
            check("R7 R8 tx ready", status[9], TXTAB[i][0]);
        end
        tx_level = 0; tx_thr = 6'd2; tick();

        // R1 sticky set, write 0 keeps, write 1 clears
        ev_frame = 1; tick(); ev_frame = 0;
        check("R1 frame set", status[1], 1);
        clr(8'hFD);
        check("R1 write 0 keeps", status[1], 1);
        clr(8'h02);
        check("R1 write 1 clears", status[1], 0);
        ev_escape = 1; ev_wake = 1; ev_txdone = 1; ev_break = 1; ev_overrun = 1;
        tick();
        ev_escape = 0; ev_wake = 0; ev_txdone = 0; ev_break = 0; ev_overrun = 0;
        check("R1 other sticky bits", status[7:0], 8'hF8);
        clr(8'hFF);
        check("R1 clear all", status[7:0], 8'h00);

        // R2 event beats clear
        ev_frame = 1; wr_en = 1; wr_clr = 8'h02; tick();
        ev_frame = 0; wr_en = 0; wr_clr = 0;
        check("R2 event wins", status[1], 1);
        clr(8'h02);

        // R3 parity gating
        parity_en = 0; ev_parity = 1; tick(); ev_parity = 0;
        parity_en = 1; #1;
        check("R3 disabled event ignored", status[0], 0);
        ev_parity = 1; tick(); ev_parity = 0;
        check("R3 enabled event", status[0], 1);
        parity_en = 0; #1;
        check("R3 reads zero when off", status[0], 0);
        parity_en = 1; #1;
        check("R3 stored bit returns", status[0], 1);
        clr(8'h01);

        // R4 R5 RTS falling in normal mode
        rts_n = 0; tick();
        check("R4 one edge no change", status[8], 0);
        tick();
        check("R4 active after two", status[8], 1);
        check("R5 not yet", status[2], 0);
        tick();
        check("R5 falling delta", status[2], 1);
        clr(8'hFF);
        check("R4 write ignored", status[8], 1);
        rts_n = 1; tick(); tick(); tick();
        check("R5 rising delta", status[2], 1);
        check("R4 inactive", status[8], 0);
        clr(8'h04);

        // R6 stop mode filter
        stop_mode = 1; rts_n = 0; tick(); tick(); tick();
        check("R6 assertion sets", status[2], 1);
        check("R6 wake high", wake, 1);
        clr(8'h04);
        check("R6 wake drops", wake, 0);
        rts_n = 1; tick(); tick(); tick(); tick();
        check("R6 release ignored", status[2], 0);
        stop_mode = 0;

        // R9 receiver idle
        rx_char_done = 1; rx_idle_now = 1; tick(); rx_char_done = 0;
        check("R9 clear wins", status[10], 0);
        rx_pin = 0; tick();
        check("R9 line low holds", status[10], 0);
        rx_pin = 1; tick();
        check("R9 set on idle", status[10], 1);
        rx_idle_now = 0;

        // R10 interrupt combine
        irq_en = 11'h002; ev_frame = 1; tick(); ev_frame = 0;
        check("R10 frame irq", irq, 1);
        irq_en = 11'h000; #1;
        check("R10 masked", irq, 0);
        clr(8'h02);
        rts_n = 0; tick(); tick(); tick();
        clr(8'h04);
        irq_en = 11'h100; #1;
        check("R10 rts level not irq", irq, 0);
        irq_en = 11'h200; #1;
        check("R10 tx ready irq", irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule